// File: doc/BRIEF.md
# Debug Instruction Injector

This block is the hart-facing memory slave of a debug controller. A halted hart spins inside a small debug address window and fetches instructions from it. The block steers that hart by rewriting the instruction words it fetches. The window has five regions: a per-hart entry table with one word per hart, a two-word code area, a program buffer, a per-hart exception table, and a little-endian exchange buffer. The hart moves register contents through the exchange buffer.

The controller hands over a decoded register-access command. The command carries the direction, the width (32 or 64 bit), the register number, and flags asking for the program buffer to run before or after the transfer. The block then patches the code area with a load or store through the exchange buffer, followed by either a jump into the program buffer or a breakpoint. It points the selected hart's entry slot at that code. A resume request patches a debug-return into the code area.

There is no handshake with the hart. The block infers halt, command completion and resume from which slot the hart fetches. It raises `busy` while a command or resume is in flight and keeps one halted flag per hart. It reports a fetch from the exception table to the controller.

Top module: `dbg_injector`

## Requirements
- R1: After reset every entry slot reads the jump-to-self word 0x0000006F, `busy` is 0 and every `halted` bit is 0.
- R2: A read of entry slot h sets `halted[h]` on the next cycle. If the slot of the hart selected by `hartSel` holds jump-to-self at that read, `busy` is 0 on the next cycle.
- R3: A command sets code word 0 (at CODE_BASE) to a transfer through the exchange address with base register x0 and funct3 010 (32 bit) or 011 (64 bit). A register write uses the load opcode 0x03 with rd = register. A register read uses the store opcode 0x23 with rs2 = register.
- R4: A command with the post-run flag sets code word 1 (at CODE_BASE+4) to a jal x0 into PBUF_BASE. Without the flag it sets code word 1 to ebreak 0x00100073.
- R5: A command sets `busy` on the next cycle. Without the pre-run flag it sets the selected entry slot to jal x0 to CODE_BASE. Every jal offset is the target minus the slot's own address, in the J-type immediate layout.
- R6: With the pre-run flag the selected entry slot jumps to PBUF_BASE, and a pending jal to CODE_BASE is held. After any entry-slot read, the next access outside the entry table writes the pending word into the selected slot, and the pending word returns to jump-to-self.
- R7: Exception slot h reads a jal back to entry slot h. A read in the exception table raises `excSet` in that cycle only while `errNone` is 1.
- R8: A resume request sets code word 0 to dret 0x7B200073, points the selected entry slot at CODE_BASE and sets `busy`. A code-area read while word 0 holds dret clears `busy` and the selected hart's `halted` bit.
- R9: Program-buffer and exchange words are writable from the hart port. Each `memBe` bit i enables byte lane i, which is bits 8i+7..8i, and the words read back as written.
- R10: An access outside every region, or a write to the entry, code or exception regions, raises `memErr` in that cycle and changes no storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe carrying a decoded register-access command |
| cmdWrite | input | 1 | 1: register write (load from exchange); 0: register read (store) |
| cmdWide | input | 1 | 1: 64-bit transfer; 0: 32-bit |
| cmdRegNum | input | 5 | Integer register number |
| cmdPreExec | input | 1 | Run the program buffer before the transfer |
| cmdPostExec | input | 1 | Run the program buffer after the transfer |
| resumeReq | input | 1 | One-cycle strobe requesting resume of the selected hart |
| hartSel | input | HW | Selected hart index |
| errNone | input | 1 | Controller error state is clear |
| memReq | input | 1 | Hart access valid this cycle |
| memWe | input | 1 | Hart access is a write |
| memAddr | input | AW | Byte address, word aligned |
| memWdata | input | 32 | Write data |
| memBe | input | 4 | Byte-lane enables for writes |
| memRdata | output | 32 | Read data, combinational |
| memErr | output | 1 | Access error, combinational |
| busy | output | 1 | Command or resume in flight |
| halted | output | NHARTS | Per-hart halted flags |
| excSet | output | 1 | Exception-table fetch with no prior error |

## Verification
The hardest case to reach is the deferred rewrite of an entry slot. The slot changes only on the first access outside the entry table after that slot was fetched, so the ports only show the change when a second fetch of the same slot follows. The stimulus follows a hart's real fetch order. With the pre-run flag it fetches the entry slot, then the program buffer, then the entry slot again to catch the jump to the code area. It then fetches the code area and finally the entry slot, where jump-to-self must appear and `busy` must drop.

// File: rtl/dbg_inj_pkg.sv
package dbg_inj_pkg;

  typedef enum logic [2:0] {
    RG_NONE, RG_ENTRY, RG_CODE, RG_PBUF, RG_EXC, RG_XCHG
  } region_e;

  localparam logic [31:0] JSELF  = 32'h0000006F;
  localparam logic [31:0] EBREAK = 32'h00100073;
  localparam logic [31:0] DRET   = 32'h7B200073;

  // Strobes from control to datapath
  typedef struct packed {
    logic        entryWr;
    logic [31:0] entryVal;
    logic        code0Wr;
    logic [31:0] code0Val;
    logic        code1Wr;
    logic [31:0] code1Val;
    logic        memWr;
  } strobe_t;

  // jal x0, off  (J-type immediate)
  function automatic logic [31:0] encJal(input int off);
    logic [20:0] o;
    o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
  endfunction

  // load/store of regNum at imm(x0)
  function automatic logic [31:0] encMove(input logic isLoad, input logic wide,
                                          input logic [4:0] regNum, input int imm);
    logic [11:0] i;
    logic [2:0]  f3;
    i  = 12'(imm);
    f3 = wide ? 3'b011 : 3'b010;
    if (isLoad) return {i, 5'd0, f3, regNum, 7'h03};
    return {i[11:5], regNum, 5'd0, f3, i[4:0], 7'h23};
  endfunction

endpackage

// File: rtl/dbg_inj_data.sv
module dbg_inj_data
  import dbg_inj_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int AW         = 12,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int PBUF_BASE  = 'h300,
  parameter int PBUF_WORDS = 4,
  parameter int EXC_BASE   = 'h400,
  parameter int XCHG_BASE  = 'h500,
  parameter int XCHG_WORDS = 2,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1,
  localparam int PW = (PBUF_WORDS > 1) ? $clog2(PBUF_WORDS) : 1,
  localparam int XW = (XCHG_WORDS > 1) ? $clog2(XCHG_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [HW-1:0] hartSel,
  input  logic [AW-1:0] memAddr,
  input  logic [31:0]   memWdata,
  input  logic [3:0]    memBe,
  output region_e       region,
  output logic [HW-1:0] fetchIdx,
  output logic [31:0]   rdata,
  output logic          selIsJself,
  output logic          code0IsDret
);

  logic [31:0] entryMem [NHARTS];
  logic [31:0] code0, code1;
  logic [31:0] pbufMem [PBUF_WORDS];
  logic [31:0] xchgMem [XCHG_WORDS];

  int          addrInt;
  logic [PW-1:0] pIdx;
  logic [XW-1:0] xIdx;
  logic [HW-1:0] excIdx;
  logic        codeHi;

  always_comb begin
    addrInt  = int'(memAddr);
    region   = RG_NONE;
    if (addrInt >= ENTRY_BASE && addrInt < ENTRY_BASE + 4*NHARTS)          region = RG_ENTRY;
    else if (addrInt >= CODE_BASE && addrInt < CODE_BASE + 8)              region = RG_CODE;
    else if (addrInt >= PBUF_BASE && addrInt < PBUF_BASE + 4*PBUF_WORDS)   region = RG_PBUF;
    else if (addrInt >= EXC_BASE && addrInt < EXC_BASE + 4*NHARTS)        region = RG_EXC;
    else if (addrInt >= XCHG_BASE && addrInt < XCHG_BASE + 4*XCHG_WORDS)   region = RG_XCHG;
    fetchIdx = HW'((addrInt - ENTRY_BASE) >>> 2);
    excIdx   = HW'((addrInt - EXC_BASE) >>> 2);
    pIdx     = PW'((addrInt - PBUF_BASE) >>> 2);
    xIdx     = XW'((addrInt - XCHG_BASE) >>> 2);
    codeHi   = ((addrInt - CODE_BASE) >>> 2) == 1;
  end

  always_comb begin
    unique case (region)
      RG_ENTRY: rdata = entryMem[fetchIdx];
      RG_CODE:  rdata = codeHi ? code1 : code0;
      RG_PBUF:  rdata = pbufMem[pIdx];
      RG_EXC:   rdata = encJal((ENTRY_BASE + 4*int'(excIdx)) - (EXC_BASE + 4*int'(excIdx)));
      RG_XCHG:  rdata = xchgMem[xIdx];
      default:  rdata = '0;
    endcase
  end

  assign selIsJself  = (entryMem[hartSel] == JSELF);
  assign code0IsDret = (code0 == DRET);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int h = 0; h < NHARTS; h++) entryMem[h] <= JSELF;
      code0 <= '0;
      code1 <= '0;
      for (int w = 0; w < PBUF_WORDS; w++) pbufMem[w] <= '0;
      for (int w = 0; w < XCHG_WORDS; w++) xchgMem[w] <= '0;
    end else begin
      if (strobe.entryWr) entryMem[hartSel] <= strobe.entryVal;
      if (strobe.code0Wr) code0 <= strobe.code0Val;
      if (strobe.code1Wr) code1 <= strobe.code1Val;
      if (strobe.memWr && region == RG_PBUF)
        for (int b = 0; b < 4; b++)
          if (memBe[b]) pbufMem[pIdx][8*b +: 8] <= memWdata[8*b +: 8];
      if (strobe.memWr && region == RG_XCHG)
        for (int b = 0; b < 4; b++)
          if (memBe[b]) xchgMem[xIdx][8*b +: 8] <= memWdata[8*b +: 8];
    end
  end

endmodule

// File: rtl/dbg_inj_ctrl.sv
module dbg_inj_ctrl
  import dbg_inj_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int PBUF_BASE  = 'h300,
  parameter int XCHG_BASE  = 'h500,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic              cmdWide,
  input  logic [4:0]        cmdRegNum,
  input  logic              cmdPreExec,
  input  logic              cmdPostExec,
  input  logic              resumeReq,
  input  logic [HW-1:0]     hartSel,
  input  logic              errNone,
  input  logic              memReq,
  input  logic              memWe,
  input  region_e           region,
  input  logic [HW-1:0]     fetchIdx,
  input  logic              selIsJself,
  input  logic              code0IsDret,
  output strobe_t           strobe,
  output logic              busy,
  output logic [NHARTS-1:0] halted,
  output logic              excSet,
  output logic              memErr
);

  logic [31:0] pending;
  logic        actionDone;
  int          slotAddr;
  logic [31:0] jToCode, jToPbuf;
  logic        fetch, entryFetch, codeFetch, applyPending, roRegion;

  always_comb begin
    slotAddr     = ENTRY_BASE + 4*int'(hartSel);
    jToCode      = encJal(CODE_BASE - slotAddr);
    jToPbuf      = encJal(PBUF_BASE - slotAddr);
    fetch        = memReq && !memWe;
    entryFetch   = fetch && region == RG_ENTRY;
    codeFetch    = fetch && region == RG_CODE;
    applyPending = memReq && region != RG_ENTRY && actionDone;
    roRegion     = region == RG_ENTRY || region == RG_CODE || region == RG_EXC;
    memErr       = memReq && (region == RG_NONE || (memWe && roRegion));
    excSet       = fetch && region == RG_EXC && errNone;
  end

  always_comb begin
    strobe       = '0;
    strobe.memWr = memReq && memWe && (region == RG_PBUF || region == RG_XCHG);
    if (cmdValid) begin
      strobe.code0Wr  = 1'b1;
      strobe.code0Val = encMove(cmdWrite, cmdWide, cmdRegNum, XCHG_BASE);
      strobe.code1Wr  = 1'b1;
      strobe.code1Val = cmdPostExec ? encJal(PBUF_BASE - (CODE_BASE + 4)) : EBREAK;
      strobe.entryWr  = 1'b1;
      strobe.entryVal = cmdPreExec ? jToPbuf : jToCode;
    end else if (resumeReq) begin
      strobe.code0Wr  = 1'b1;
      strobe.code0Val = DRET;
      strobe.entryWr  = 1'b1;
      strobe.entryVal = jToCode;
    end else if (applyPending) begin
      strobe.entryWr  = 1'b1;
      strobe.entryVal = pending;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      halted     <= '0;
      pending    <= JSELF;
      actionDone <= 1'b0;
    end else begin
      if (cmdValid || resumeReq)          busy <= 1'b1;
      else if (entryFetch && selIsJself)  busy <= 1'b0;
      else if (codeFetch && code0IsDret)  busy <= 1'b0;

      if (entryFetch) halted[fetchIdx] <= 1'b1;
      else if (codeFetch && code0IsDret) halted[hartSel] <= 1'b0;

      if (cmdValid && cmdPreExec) pending <= jToCode;
      else if (applyPending && !cmdValid && !resumeReq) pending <= JSELF;

      if (entryFetch) actionDone <= 1'b1;
      else if (applyPending && !cmdValid && !resumeReq) actionDone <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_injector.sv
module dbg_injector
  import dbg_inj_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int AW         = 12,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int PBUF_BASE  = 'h300,
  parameter int PBUF_WORDS = 4,
  parameter int EXC_BASE   = 'h400,
  parameter int XCHG_BASE  = 'h500,
  parameter int XCHG_WORDS = 2,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic              cmdWide,
  input  logic [4:0]        cmdRegNum,
  input  logic              cmdPreExec,
  input  logic              cmdPostExec,
  input  logic              resumeReq,
  input  logic [HW-1:0]     hartSel,
  input  logic              errNone,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [AW-1:0]     memAddr,
  input  logic [31:0]       memWdata,
  input  logic [3:0]        memBe,
  output logic [31:0]       memRdata,
  output logic              memErr,
  output logic              busy,
  output logic [NHARTS-1:0] halted,
  output logic              excSet
);

  strobe_t       strobe;
  region_e       region;
  logic [HW-1:0] fetchIdx;
  logic          selIsJself, code0IsDret;

  dbg_inj_ctrl #(
    .NHARTS(NHARTS), .ENTRY_BASE(ENTRY_BASE), .CODE_BASE(CODE_BASE),
    .PBUF_BASE(PBUF_BASE), .XCHG_BASE(XCHG_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdWide(cmdWide), .cmdRegNum(cmdRegNum), .cmdPreExec(cmdPreExec),
    .cmdPostExec(cmdPostExec), .resumeReq(resumeReq), .hartSel(hartSel),
    .errNone(errNone), .memReq(memReq), .memWe(memWe), .region(region),
    .fetchIdx(fetchIdx), .selIsJself(selIsJself), .code0IsDret(code0IsDret),
    .strobe(strobe), .busy(busy), .halted(halted), .excSet(excSet),
    .memErr(memErr)
  );

  dbg_inj_data #(
    .NHARTS(NHARTS), .AW(AW), .ENTRY_BASE(ENTRY_BASE), .CODE_BASE(CODE_BASE),
    .PBUF_BASE(PBUF_BASE), .PBUF_WORDS(PBUF_WORDS), .EXC_BASE(EXC_BASE),
    .XCHG_BASE(XCHG_BASE), .XCHG_WORDS(XCHG_WORDS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hartSel(hartSel),
    .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe), .region(region),
    .fetchIdx(fetchIdx), .rdata(memRdata), .selIsJself(selIsJself),
    .code0IsDret(code0IsDret)
  );

endmodule

// File: rtl/dbg_injector_chk.sv
module dbg_injector_chk #(
  parameter int NHARTS     = 4,
  parameter int AW         = 12,
  parameter int ENTRY_BASE = 'h100,
  parameter int CODE_BASE  = 'h200,
  parameter int PBUF_BASE  = 'h300,
  parameter int PBUF_WORDS = 4,
  parameter int EXC_BASE   = 'h400,
  parameter int XCHG_BASE  = 'h500,
  parameter int XCHG_WORDS = 2,
  localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              resumeReq,
  input logic              errNone,
  input logic              memReq,
  input logic              memWe,
  input logic [AW-1:0]     memAddr,
  input logic [31:0]       memRdata,
  input logic              memErr,
  input logic              busy,
  input logic [NHARTS-1:0] halted,
  input logic              excSet
);

  int            a;
  logic          inEntry, inCode, inPbuf, inExc, inXchg, inAny;
  logic [HW-1:0] entIdx;

  always_comb begin
    a       = int'(memAddr);
    inEntry = a >= ENTRY_BASE && a < ENTRY_BASE + 4*NHARTS;
    inCode  = a >= CODE_BASE && a < CODE_BASE + 8;
    inPbuf  = a >= PBUF_BASE && a < PBUF_BASE + 4*PBUF_WORDS;
    inExc   = a >= EXC_BASE && a < EXC_BASE + 4*NHARTS;
    inXchg  = a >= XCHG_BASE && a < XCHG_BASE + 4*XCHG_WORDS;
    inAny   = inEntry || inCode || inPbuf || inExc || inXchg;
    entIdx  = HW'((a - ENTRY_BASE) >>> 2);
  end

  assert_entry_fetch_halts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && inEntry) |=> halted[$past(entIdx)]);

  assert_cmd_sets_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> busy);

  assert_exc_only_on_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    excSet |-> (memReq && !memWe && inExc && errNone));

  assert_dret_fetch_clears_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && inCode && memRdata == 32'h7B200073 && !cmdValid && !resumeReq)
      |=> !busy);

  assert_unmapped_errors_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !inAny) |-> memErr);

endmodule

bind dbg_injector dbg_injector_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .resumeReq(resumeReq),
  .errNone(errNone), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memRdata(memRdata), .memErr(memErr), .busy(busy), .halted(halted),
  .excSet(excSet)
);

// File: tb/dbg_injector_test.sv
module dbg_injector_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdWrite = 0, cmdWide = 0, cmdPreExec = 0, cmdPostExec = 0;
  logic [4:0] cmdRegNum = 0;
  logic resumeReq = 0, errNone = 1;
  logic [1:0] hartSel = 0;
  logic memReq = 0, memWe = 0;
  logic [11:0] memAddr = 0;
  logic [31:0] memWdata = 0;
  logic [3:0] memBe = 0;
  logic [31:0] memRdata;
  logic memErr, busy, excSet;
  logic [3:0] halted;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] data;
    logic        chkData;
    logic        err;
    logic        exc;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_injector uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdWide(cmdWide), .cmdRegNum(cmdRegNum), .cmdPreExec(cmdPreExec),
    .cmdPostExec(cmdPostExec), .resumeReq(resumeReq), .hartSel(hartSel),
    .errNone(errNone), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .memRdata(memRdata), .memErr(memErr),
    .busy(busy), .halted(halted), .excSet(excSet)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: compare each hart access against the scoreboard
  always @(negedge clk) begin
    if (memReq && !done) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=0x%08h expected=item", memRdata);
      end else begin
        exp_t it;
        it = q.pop_front();
        checkEq({it.tag, " err"}, 32'(memErr), 32'(it.err));
        checkEq({it.tag, " exc"}, 32'(excSet), 32'(it.exc));
        if (it.chkData) checkEq({it.tag, " data"}, memRdata, it.data);
      end
    end
  end

  task automatic acc(input logic we, input logic [11:0] a, input logic [31:0] wd,
                     input logic [3:0] be, input logic [31:0] ed, input logic cd,
                     input logic ee, input logic ex, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.data = ed; it.chkData = cd; it.err = ee; it.exc = ex; it.tag = tag;
    q.push_back(it);
    memReq = 1; memWe = we; memAddr = a; memWdata = wd; memBe = be;
    @(posedge clk); #1;
    memReq = 0; memWe = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] ed, input string tag);
    acc(0, a, 0, 0, ed, 1, 0, 0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input logic [3:0] be,
                    input logic ee, input string tag);
    acc(1, a, wd, be, 0, 0, ee, 0, tag);
  endtask

  task automatic issue(input logic w, input logic wide, input logic [4:0] r,
                       input logic pre, input logic post);
    @(posedge clk); #1;
    cmdValid = 1; cmdWrite = w; cmdWide = wide; cmdRegNum = r;
    cmdPreExec = pre; cmdPostExec = post;
    @(posedge clk); #1;
    cmdValid = 0;
  endtask

  task automatic resume();
    @(posedge clk); #1; resumeReq = 1;
    @(posedge clk); #1; resumeReq = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    checkEq("R1 busy", 32'(busy), 0);
    checkEq("R1 halted", 32'(halted), 0);
    rd(12'h100, 32'h0000006F, "R1 entry0 idle");
    // R2 halt on entry fetch, idle slot keeps busy low
    checkEq("R2 halted after fetch", 32'(halted), 32'h1);
    checkEq("R2 busy idle", 32'(busy), 0);

    // Read x5, 32 bit, no pre/post, hart 0
    issue(0, 0, 5'd5, 0, 0);
    checkEq("R5 busy set", 32'(busy), 1);
    rd(12'h100, 32'h1000006F, "R5 entry0 jal code");
    rd(12'h200, 32'h50502023, "R3 sw x5");
    wr(12'h500, 32'hA1B2C3D4, 4'hF, 0, "R9 xchg write");
    checkEq("R2 busy in flight", 32'(busy), 1);
    rd(12'h204, 32'h00100073, "R4 ebreak");
    rd(12'h100, 32'h0000006F, "R6 entry0 restored");
    checkEq("R2 busy cleared", 32'(busy), 0);

    // R9 byte lanes and program buffer
    wr(12'h500, 32'h00EE0000, 4'b0100, 0, "R9 lane2");
    rd(12'h500, 32'hA1EEC3D4, "R9 xchg readback");
    wr(12'h30C, 32'hCAFEF00D, 4'hF, 0, "R9 pbuf write");
    rd(12'h30C, 32'hCAFEF00D, "R9 pbuf readback");

    // Write x7, 64 bit, pre+post, hart 1
    hartSel = 1;
    issue(1, 1, 5'd7, 1, 1);
    rd(12'h104, 32'h1FC0006F, "R6 entry1 jal pbuf");
    checkEq("R2 halted h1", 32'(halted), 32'h3);
    rd(12'h300, 32'h00000000, "R6 pbuf fetch");
    rd(12'h104, 32'h0FC0006F, "R6 pending applied");
    rd(12'h200, 32'h50003383, "R3 ld x7");
    rd(12'h204, 32'h0FC0006F, "R4 jal pbuf");
    checkEq("R6 busy in flight", 32'(busy), 1);
    rd(12'h300, 32'h00000000, "R6 pbuf post");
    rd(12'h104, 32'h0000006F, "R6 entry1 self");
    checkEq("R2 busy cleared h1", 32'(busy), 0);

    // R7 exception table
    errNone = 1;
    acc(0, 12'h404, 0, 0, 32'hD01FF06F, 1, 0, 1, "R7 exc1 with errNone");
    errNone = 0;
    acc(0, 12'h400, 0, 0, 32'hD01FF06F, 1, 0, 0, "R7 exc0 masked");
    errNone = 1;

    // R8 resume hart 0
    hartSel = 0;
    resume();
    checkEq("R8 busy set", 32'(busy), 1);
    rd(12'h100, 32'h1000006F, "R8 entry0 jal code");
    rd(12'h200, 32'h7B200073, "R8 dret");
    checkEq("R8 busy cleared", 32'(busy), 0);
    checkEq("R8 halted h0 cleared", 32'(halted), 32'h2);

    // R10 errors
    acc(0, 12'h600, 0, 0, 0, 0, 1, 0, "R10 unmapped");
    acc(0, 12'h508, 0, 0, 0, 0, 1, 0, "R10 past xchg");
    wr(12'h108, 32'h12345678, 4'hF, 1, "R10 entry write");
    rd(12'h108, 32'h0000006F, "R10 entry unchanged");
    wr(12'h200, 32'h12345678, 4'hF, 1, "R10 code write");
    rd(12'h200, 32'h7B200073, "R10 code unchanged");

    repeat (2) @(posedge clk);
    checkEq("scoreboard drained", 32'(q.size()), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule